// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, for each incoming frame, whether the frame is kept or dropped. The decision uses only the 48-bit destination address, which the upstream parser presents on `da_addr` together with a one-cycle strobe `da_valid`. There are three ways a frame can pass. The first is promiscuous mode, which accepts every frame. The second is a bank of exact-match address slots, each with its own enable. The third is a 64-bin multicast hash table. The hash table only applies to group-addressed frames, and only while it is switched on.

Software loads the settings through a simple 16-bit write port (`cfg_we`, `cfg_addr`, `cfg_wdata`). The accept/reject result appears on `dec_accept`, qualified by a one-cycle `dec_valid` pulse, two clock cycles after the strobe. A new address may be presented on every cycle.

Internally the block is a two-stage pipeline. Stage one compares the address against every slot and computes the hash bin. Stage two reads the mode bits and the hash table and registers the decision. Slot contents and enables are sampled in the strobe cycle. The mode bits and hash words are sampled one cycle later. Software is expected to change settings only while no address is in flight.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, slot 0 holds 48'hFFFF_FFFF_FFFF and is enabled, all other slots are cleared and disabled, all hash words are zero, and both mode bits are clear. As a result, the broadcast address is accepted and every other address is rejected, and `dec_valid` and `dec_accept` are low.
- R2: For each cycle in which `da_valid` is high, `dec_valid` is high for exactly one cycle, two cycles later, and at no other time; strobes in back-to-back cycles give back-to-back decisions in the same order.
- R3: `da_addr[7:0]` carries the first address byte on the wire (byte0) and `da_addr[47:40]` carries byte5. Slot s is written as three words: at config address 8+4*s the low word byte1:byte0, at 9+4*s the mid word byte3:byte2, and at 10+4*s the high word byte5:byte4. An address equal to an enabled slot is accepted.
- R4: Slot enables are the low NUM_SLOTS bits written at config address 1 (bit s enables slot s). A slot whose enable is clear never causes an accept, even when its contents equal the address.
- R5: Config address 0 holds the mode bits: bit0 is promiscuous and bit1 is hash enable. While promiscuous is set, every address is accepted.
- R6: The hash bin is computed as follows. Run a reflected CRC-32 (polynomial 0xEDB88320), starting from all ones, over byte0 to byte5, taking each byte least significant bit first, with no final inversion. Reverse all 32 bits of the result and take bits [28:23] as the 6-bit bin b. Hash word k, at config address 2+k, holds bins 16k to 16k+15, and bin b maps to bit b[3:0] of word b[5:4]. A group address (`da_addr[0]` = 1) is accepted when hash enable is set and the bit for its bin is 1.
- R7: While hash enable is clear, the hash words have no effect on the decision.
- R8: An address with `da_addr[0]` = 0 is never accepted through the hash table, even when all hash bits are set.
- R9: With hash enable set and all four hash words at 0xFFFF, every group address is accepted.
- R10: `dec_accept` is low in every cycle in which `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_ADDR_W | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte0 in bits [7:0] |
| dec_valid | output | 1 | Decision valid pulse |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
The bench builds the block with NUM_SLOTS = 4 and CFG_ADDR_W = 6. With these values there is a slot that is programmed but left disabled, next to the broadcast slot and a unicast slot. Every register address, including the high word of the top slot at 22, fits in the address space. The scoreboard model recomputes the hash bin byte by byte from its own shadow of the settings. This lets it test single-bin hash programming, the all-ones table, hash-off and unicast bypass, promiscuous mode, and a back-to-back stream of random addresses, against both the expected decision and the two-cycle arrival time.

// File: rtl/daf_pkg.sv
`timescale 1ns/1ps
package daf_pkg;
    localparam int DA_W        = 48;
    localparam int WORD_W      = 16;
    localparam int WORDS_PER_A = DA_W / WORD_W;
    localparam int BIN_W       = 6;
    localparam int HASH_BINS   = 1 << BIN_W;
    localparam int HASH_WORDS  = HASH_BINS / WORD_W;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // configuration word map
    localparam int MODE_ADDR   = 0;
    localparam int EN_ADDR     = 1;
    localparam int HASH_BASE   = 2;
    localparam int SLOT_BASE   = 8;
    localparam int SLOT_STRIDE = 4;

    // bit-serial reflected CRC over the address, byte0 bit0 first,
    // then bin = bits [28:23] of the fully reversed remainder
    function automatic logic [BIN_W-1:0] hash_bin(input logic [DA_W-1:0] a);
        logic [31:0]      c;
        logic             fb;
        logic [BIN_W-1:0] b;
        c = '1;
        for (int i = 0; i < DA_W; i++) begin
            fb = c[0] ^ a[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY;
        end
        for (int j = 0; j < BIN_W; j++) b[BIN_W-1-j] = c[3+j];
        return b;
    endfunction
endpackage

// File: rtl/daf_cfg_regs.sv
`timescale 1ns/1ps
module daf_cfg_regs
    import daf_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int CFG_ADDR_W = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [CFG_ADDR_W-1:0]            cfg_addr,
    input  logic [WORD_W-1:0]                cfg_wdata,
    output logic                             promisc,
    output logic                             hash_en,
    output logic [NUM_SLOTS-1:0]             slot_en,
    output logic [HASH_BINS-1:0]             hash_tbl,
    output logic [NUM_SLOTS-1:0][DA_W-1:0]   slot_addr
);
    localparam logic [NUM_SLOTS-1:0] EN_RESET = NUM_SLOTS'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            promisc  <= 1'b0;
            hash_en  <= 1'b0;
            slot_en  <= EN_RESET;
            hash_tbl <= '0;
            for (int s = 0; s < NUM_SLOTS; s++)
                slot_addr[s] <= (s == 0) ? '1 : '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_ADDR_W'(MODE_ADDR)) begin
                promisc <= cfg_wdata[0];
                hash_en <= cfg_wdata[1];
            end
            if (cfg_addr == CFG_ADDR_W'(EN_ADDR))
                slot_en <= cfg_wdata[NUM_SLOTS-1:0];
            for (int k = 0; k < HASH_WORDS; k++)
                if (cfg_addr == CFG_ADDR_W'(HASH_BASE + k))
                    hash_tbl[k*WORD_W +: WORD_W] <= cfg_wdata;
            for (int s = 0; s < NUM_SLOTS; s++)
                for (int w = 0; w < WORDS_PER_A; w++)
                    if (cfg_addr == CFG_ADDR_W'(SLOT_BASE + SLOT_STRIDE*s + w))
                        slot_addr[s][w*WORD_W +: WORD_W] <= cfg_wdata;
        end
    end
endmodule

// File: rtl/daf_slot_match.sv
`timescale 1ns/1ps
module daf_slot_match
    import daf_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [DA_W-1:0]                 da_addr,
    input  logic [NUM_SLOTS-1:0]            slot_en,
    input  logic [NUM_SLOTS-1:0][DA_W-1:0]  slot_addr,
    output logic [NUM_SLOTS-1:0]            hit
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign hit[s] = slot_en[s] && (slot_addr[s] == da_addr);
    end
endmodule

// File: rtl/daf_hash_index.sv
`timescale 1ns/1ps
module daf_hash_index
    import daf_pkg::*;
(
    input  logic [DA_W-1:0]  da_addr,
    output logic [BIN_W-1:0] bin
);
    assign bin = hash_bin(da_addr);
endmodule

// File: rtl/dst_addr_filter.sv
`timescale 1ns/1ps
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int CFG_ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [15:0]           cfg_wdata,
    input  logic                  da_valid,
    input  logic [47:0]           da_addr,
    output logic                  dec_valid,
    output logic                  dec_accept
);
    logic                           promisc;
    logic                           hash_en;
    logic [NUM_SLOTS-1:0]           slot_en;
    logic [HASH_BINS-1:0]           hash_tbl;
    logic [NUM_SLOTS-1:0][DA_W-1:0] slot_addr;
    logic [NUM_SLOTS-1:0]           hit;
    logic [BIN_W-1:0]               bin;

    // stage one registers
    logic                           s1_valid;
    logic [NUM_SLOTS-1:0]           s1_hit;
    logic                           s1_grp;
    logic [BIN_W-1:0]               s1_bin;
    logic                           accept_d;

    daf_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .CFG_ADDR_W(CFG_ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .promisc(promisc), .hash_en(hash_en),
        .slot_en(slot_en), .hash_tbl(hash_tbl), .slot_addr(slot_addr)
    );

    daf_slot_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
        .da_addr(da_addr), .slot_en(slot_en), .slot_addr(slot_addr), .hit(hit)
    );

    daf_hash_index u_hash (.da_addr(da_addr), .bin(bin));

    // stage one: compare results and hash bin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hit   <= '0;
            s1_grp   <= 1'b0;
            s1_bin   <= '0;
        end else begin
            s1_valid <= da_valid;
            s1_hit   <= da_valid ? hit : '0;
            s1_grp   <= da_valid & da_addr[0];
            s1_bin   <= bin;
        end
    end

    // stage two: combine filters
    always_comb begin
        accept_d = s1_valid &
                   (promisc | (|s1_hit) | (s1_grp & hash_en & hash_tbl[s1_bin]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= s1_valid;
            dec_accept <= accept_d;
        end
    end
endmodule

// File: rtl/dst_addr_filter_chk.sv
`timescale 1ns/1ps
module dst_addr_filter_chk #(
    parameter int NUM_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 da_valid,
    input logic                 dec_valid,
    input logic                 dec_accept,
    input logic                 promisc,
    input logic                 hash_en,
    input logic [NUM_SLOTS-1:0] slot_en,
    input logic [NUM_SLOTS-1:0] s1_hit,
    input logic                 s1_grp
);
    logic v1, v2;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
        end else begin
            v1 <= da_valid;
            v2 <= v1;
        end
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == v2);

    a_r10_idle_reject: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);

    a_r5_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(promisc)) |-> dec_accept);

    a_r3_exact_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ($past(s1_hit) != '0)) |-> dec_accept);

    a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hit & ~$past(slot_en)) == '0);

    a_r7_hash_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(promisc) && !$past(hash_en) && ($past(s1_hit) == '0))
        |-> !dec_accept);

    a_r8_unicast: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(promisc) && !$past(s1_grp) && ($past(s1_hit) == '0))
        |-> !dec_accept);
endmodule

bind dst_addr_filter dst_addr_filter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .promisc(promisc), .hash_en(hash_en),
    .slot_en(slot_en), .s1_hit(s1_hit), .s1_grp(s1_grp)
);

// File: tb/dst_addr_filter_test.sv
`timescale 1ns/1ps
module dst_addr_filter_test;
    localparam int NSLOT = 4;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          da_valid = 1'b0;
    logic [47:0]   da_addr = '0;
    logic          dec_valid, dec_accept;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // bench shadow of the settings
    bit          m_promisc, m_hash_en;
    bit [NSLOT-1:0] m_en;
    logic [47:0] m_slot [NSLOT];
    logic [15:0] m_hash [4];

    bit    exp_q [$];
    int    cyc_q [$];
    string tag_q [$];

    dst_addr_filter #(.NUM_SLOTS(NSLOT), .CFG_ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_addr(da_addr),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_bin(logic [47:0] a);
        logic [31:0] c, r;
        c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            c = c ^ {24'd0, a[8*b +: 8]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        for (int i = 0; i < 32; i++) r[i] = c[31-i];
        return r[28:23];
    endfunction

    function automatic bit model(logic [47:0] a);
        logic [5:0] b;
        bit acc;
        b   = ref_bin(a);
        acc = m_promisc;
        for (int s = 0; s < NSLOT; s++)
            if (m_en[s] && m_slot[s] == a) acc = 1;
        if (a[0] && m_hash_en && m_hash[b[5:4]][b[3:0]]) acc = 1;
        return acc;
    endfunction

    task automatic cfg_wr(int a, logic [15:0] d);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 0) begin m_promisc = d[0]; m_hash_en = d[1]; end
        if (a == 1) m_en = d[NSLOT-1:0];
        if (a >= 2 && a <= 5) m_hash[a-2] = d;
        for (int s = 0; s < NSLOT; s++)
            for (int w = 0; w < 3; w++)
                if (a == 8 + 4*s + w) m_slot[s][16*w +: 16] = d;
    endtask

    task automatic wr_slot(int s, logic [47:0] v);
        for (int w = 0; w < 3; w++) cfg_wr(8 + 4*s + w, v[16*w +: 16]);
    endtask

    // driver: strobe one address, push expectation
    task automatic send(logic [47:0] a, string tag);
        exp_q.push_back(model(a));
        cyc_q.push_back(cyc + 2);
        tag_q.push_back(tag);
        da_valid = 1'b1; da_addr = a;
        @(negedge clk);
        da_valid = 1'b0;
    endtask

    function automatic logic [47:0] rnd_addr(bit grp);
        logic [47:0] a;
        a = {$urandom, $urandom};
        a[0] = grp;
        return a;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dec_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected dec_valid", 1, 0);
                end else begin
                    string t;
                    t = tag_q.pop_front();
                    chk({t, " accept"}, dec_accept, exp_q.pop_front());
                    chk("R2 latency", cyc, cyc_q.pop_front());
                end
            end else begin
                chk("R10 idle accept", dec_accept, 0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] mc, a1;
        logic [5:0]  b;
        m_promisc = 0; m_hash_en = 0; m_en = 1;
        for (int s = 0; s < NSLOT; s++) m_slot[s] = (s == 0) ? '1 : '0;
        for (int k = 0; k < 4; k++) m_hash[k] = '0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset dec_valid", dec_valid, 0);
        chk("R1 reset dec_accept", dec_accept, 0);

        // reset defaults
        send(48'hFFFF_FFFF_FFFF, "R1 broadcast");
        send(48'h0913_0043_0700, "R1 unicast");
        mc = 48'h0100_005E_0001;
        send(mc, "R7 multicast at reset");

        // exact match
        a1 = 48'h0913_0043_0700;
        wr_slot(1, a1);
        wr_slot(2, 48'hAAAA_5555_1234);
        cfg_wr(1, 16'h0003);
        send(a1, "R3 slot1 hit");
        send(48'h0913_0043_0702, "R3 near miss");
        send(48'hAAAA_5555_1234, "R4 disabled slot2");
        send(48'hFFFF_FFFF_FFFF, "R3 broadcast slot0");
        cfg_wr(1, 16'h0001);
        send(a1, "R4 slot1 disabled");

        // hash single bin
        b = ref_bin(mc);
        cfg_wr(2 + b[5:4], 16'(1 << b[3:0]));
        send(mc, "R7 hash off");
        cfg_wr(0, 16'h0002);
        send(mc, "R6 bin hit");
        for (int i = 0; i < 8; i++) send(rnd_addr(1), "R6 other bins");

        // all ones
        for (int k = 0; k < 4; k++) cfg_wr(2 + k, 16'hFFFF);
        for (int i = 0; i < 8; i++) send(rnd_addr(0), "R8 unicast bypass");
        for (int i = 0; i < 8; i++) send(rnd_addr(1), "R9 all multicast");
        cfg_wr(0, 16'h0000);
        for (int i = 0; i < 4; i++) send(rnd_addr(1), "R7 words ignored");

        // promiscuous
        cfg_wr(0, 16'h0001);
        for (int i = 0; i < 8; i++) send(rnd_addr(i[0]), "R5 promisc");

        // back-to-back mixed stream
        cfg_wr(0, 16'h0002);
        cfg_wr(1, 16'h0003);
        for (int k = 0; k < 4; k++) cfg_wr(2 + k, 16'($urandom));
        for (int i = 0; i < 24; i++) begin
            if (i % 5 == 0) send(a1, "R2 stream slot");
            else if (i % 7 == 0) send(48'hFFFF_FFFF_FFFF, "R2 stream bcast");
            else send(rnd_addr(i[1]), "R2 stream");
        end

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1;
        chk("R2 leftover", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule